// File: doc/BRIEF.md
# Dual-Slope Conversion Controller

This block sequences an integrating analog-to-digital measurement. It drives an external analog switch, and through it an external integrator and comparator. After a start request it connects the integrator to the unknown input for a fixed number of clocks. It then switches the integrator to the reference and times the run-down with the same counter until the comparator reports that the threshold has been crossed. Only the run-down count is kept. It is written into a result register, and a one-clock completion pulse marks the update.

One clock times both phases, so the result depends only on the ratio of the two phase lengths. Clock drift that is slow compared with one conversion cancels out. A full-scale phase lasts about 2^N clocks, so each extra bit of resolution roughly doubles the conversion time. A run-down that never trips the comparator is clamped to full scale and flagged as out of range.

Top module: `dslope_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ref_sel_o` is 0, `done_o` is 0, `result_o` is 0 and `ovr_o` is 0. The controller is idle with its counter cleared, and this applies even if reset arrives mid-conversion.
- R2: A `start_i` high at a clock edge while idle starts the charge phase. `ref_sel_o` stays 0 (input selected) for exactly `INT_TERM` clocks and then goes to 1 (reference selected).
- R3: The counter is cleared at the switch to the reference and increments once per clock. If `cmp_i` is first seen high at the edge that ends the j-th reference cycle (j counted from 0), j is written to `result_o` and `ref_sel_o` returns to 0 on the next cycle. `ref_sel_o` is therefore high for j+1 clocks.
- R4: `done_o` is high for exactly one clock. That clock is the cycle right after the reference phase, and `result_o` and `ovr_o` already hold the new values in that cycle.
- R5: `result_o` and `ovr_o` keep their values until the next conversion completes.
- R6: If `cmp_i` is still low at the edge that ends reference cycle 2^N-1, the result is clamped to all ones and `ovr_o` is set to 1. A completion with the comparator tripped, including at j = 2^N-1, sets `ovr_o` to 0.
- R7: `start_i` has no effect during the charge phase, the reference phase or the completion cycle. Phase lengths and the result are unchanged, and no second conversion follows.
- R8: `cmp_i` has no effect outside the reference phase. A comparator held high during the charge phase neither shortens that phase nor changes the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both phases |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, sampled only when idle |
| cmp_i | input | 1 | Comparator: 1 means the integrator has returned to the threshold |
| ref_sel_o | output | 1 | Switch select: 0 = analog input, 1 = reference |
| done_o | output | 1 | One-clock completion pulse |
| result_o | output | CNT_W | Latched run-down count |
| ovr_o | output | 1 | Run-down count saturated without a comparator trip |

## Verification
A wrong internal state shows up at the ports within one conversion.

- A counter that is not cleared at the phase switch offsets `result_o` by the leftover charge count.
- A wrong terminal compare moves the rising edge of `ref_sel_o` away from clock `INT_TERM`. The bench measures that edge directly.
- A sequencer that re-enters the charge phase on a stray start, or that misses the saturation limit, shows as an extra or missing `done_o` pulse, a reference-phase length other than j+1, or a wrong `ovr_o`.

Each of these is visible by the `done_o` cycle of the conversion concerned.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INT   = 2'd1,
        ST_DEINT = 2'd2,
        ST_DONE  = 2'd3
    } ds_state_e;

    typedef struct packed {
        logic clr;
        logic inc;
    } cnt_cmd_t;

    typedef struct packed {
        logic cap;
        logic sat;
    } cap_cmd_t;

    function automatic logic accepts_start(ds_state_e s);
        return s == ST_IDLE;
    endfunction

endpackage

// File: rtl/dslope_cnt.sv
module dslope_cnt
    import dslope_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_cmd_t         cmd_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || cmd_i.clr) begin
            cnt_q <= '0;
        end else if (cmd_i.inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
    import dslope_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned INT_TERM = (1 << CNT_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cmp_i,
    input  logic [CNT_W-1:0] cnt_i,
    output cnt_cmd_t         cnt_cmd_o,
    output cap_cmd_t         cap_cmd_o,
    output logic             ref_sel_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] TERM_W   = CNT_W'(INT_TERM);
    localparam logic [CNT_W-1:0] LAST_INT = CNT_W'(INT_TERM - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    ds_state_e state_q, state_d;
    cnt_cmd_t  cnt_cmd;
    cap_cmd_t  cap_cmd;

    always_comb begin
        state_d = state_q;
        cnt_cmd = '0;
        cap_cmd = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i && accepts_start(state_q)) begin
                    state_d     = ST_INT;
                    cnt_cmd.clr = 1'b1;
                end
            end
            ST_INT: begin
                if (cnt_i == LAST_INT) begin
                    state_d     = ST_DEINT;
                    cnt_cmd.clr = 1'b1;
                end else begin
                    cnt_cmd.inc = 1'b1;
                end
            end
            ST_DEINT: begin
                if (cmp_i) begin
                    state_d     = ST_DONE;
                    cap_cmd.cap = 1'b1;
                end else if (cnt_i == CNT_MAX) begin
                    state_d     = ST_DONE;
                    cap_cmd.cap = 1'b1;
                    cap_cmd.sat = 1'b1;
                end else begin
                    cnt_cmd.inc = 1'b1;
                end
            end
            ST_DONE: begin
                state_d     = ST_IDLE;
                cnt_cmd.clr = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_cmd_o = cnt_cmd;
    assign cap_cmd_o = cap_cmd;
    assign ref_sel_o = (state_q == ST_DEINT);
    assign done_o    = (state_q == ST_DONE);

    AST_INT_BELOW_TERM: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_INT) |-> (cnt_i < TERM_W)); // R2

    AST_DEINT_STARTS_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_sel_o) |-> (cnt_i == '0)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R4

    AST_INT_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> (state_q != ST_INT || $past(state_q) == ST_INT)); // R7

endmodule

// File: rtl/dslope_res.sv
module dslope_res
    import dslope_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  cap_cmd_t         cap_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] res_o,
    output logic             ovr_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] res_q;
    logic             ovr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            ovr_q <= 1'b0;
        end else if (cap_i.cap) begin
            res_q <= cap_i.sat ? CNT_MAX : cnt_i;
            ovr_q <= cap_i.sat;
        end
    end

    assign res_o = res_q;
    assign ovr_o = ovr_q;

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap_i.cap |=> ($stable(res_q) && $stable(ovr_q))); // R5

    AST_OVR_FULLSCALE: assert property (@(posedge clk) disable iff (rst)
        ovr_q |-> (res_q == CNT_MAX)); // R6

endmodule

// File: rtl/dslope_ctrl.sv
module dslope_ctrl
    import dslope_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned INT_TERM = (1 << CNT_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic             ref_sel_o,
    output logic             done_o,
    output logic [CNT_W-1:0] result_o,
    output logic             ovr_o
);

    cnt_cmd_t         cnt_cmd;
    cap_cmd_t         cap_cmd;
    logic [CNT_W-1:0] cnt;

    dslope_seq #(
        .CNT_W    (CNT_W),
        .INT_TERM (INT_TERM)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .cmp_i     (cmp_i),
        .cnt_i     (cnt),
        .cnt_cmd_o (cnt_cmd),
        .cap_cmd_o (cap_cmd),
        .ref_sel_o (ref_sel_o),
        .done_o    (done_o)
    );

    dslope_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .cmd_i (cnt_cmd),
        .cnt_o (cnt)
    );

    dslope_res #(
        .CNT_W (CNT_W)
    ) u_res (
        .clk   (clk),
        .rst   (rst),
        .cap_i (cap_cmd),
        .cnt_i (cnt),
        .res_o (result_o),
        .ovr_o (ovr_o)
    );

endmodule

// File: tb/sim_dslope_ctrl.sv
module sim_dslope_ctrl;

    localparam int CLK_NS = 10;
    localparam int W      = 8;
    localparam int TERM   = (1 << W) - 1;
    localparam int MAXV   = (1 << W) - 1;

    typedef struct {
        int res;
        int ovr;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         cmp_i = 1'b0;
    logic         ref_sel_o;
    logic         done_o;
    logic [W-1:0] result_o;
    logic         ovr_o;

    int   checks = 0;
    int   failures = 0;
    exp_t sb_q[$];
    int   k_cur = 0;
    int   ref_n = 0;
    bit   force_cmp = 1'b0;
    int   last_res = 0;
    int   last_ovr = 0;
    int   pushes = 0;
    int   dones = 0;
    bit   prev_done = 1'b0;

    dslope_ctrl #(.CNT_W(W), .INT_TERM(TERM)) u0 (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .cmp_i     (cmp_i),
        .ref_sel_o (ref_sel_o),
        .done_o    (done_o),
        .result_o  (result_o),
        .ovr_o     (ovr_o)
    );

    always #(CLK_NS / 2) clk = ~clk;

    function automatic void check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endfunction

    // Comparator model: trips once the reference phase has lasted k_cur cycles.
    always @(negedge clk) begin
        if (rst) begin
            ref_n = 0;
            cmp_i = 1'b0;
        end else if (ref_sel_o) begin
            cmp_i = (ref_n >= k_cur);
            ref_n++;
        end else begin
            ref_n = 0;
            cmp_i = force_cmp;
        end
    end

    // Monitor: pops the scoreboard on every completion pulse.
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done && done_o) check(1'b0, "R4 done longer than one clock", 1, 0);
            if (done_o) begin
                dones++;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R7 unexpected completion", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(int'(result_o) == e.res, "R3/R4 result", int'(result_o), e.res);
                    check(int'(ovr_o) == e.ovr, "R6 overrange flag", int'(ovr_o), e.ovr);
                end
            end
            prev_done = done_o;
        end else begin
            prev_done = 1'b0;
        end
    end

    task automatic run_conv(input int k, input bit poke_start, input bit cmp_noise);
        int   n;
        int   m;
        int   exp_m;
        exp_t e;
        e.res = (k > MAXV) ? MAXV : k;
        e.ovr = (k > MAXV) ? 1 : 0;
        exp_m = ((k > MAXV) ? MAXV : k) + 1;
        k_cur = k;
        sb_q.push_back(e);
        pushes++;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        n = 0;
        while (!ref_sel_o && n < TERM + 10) begin
            start_i   = poke_start && (n == 5);
            force_cmp = cmp_noise;
            if (n == 3) check(int'(result_o) == last_res && int'(ovr_o) == last_ovr,
                              "R5 result held", int'(result_o), last_res);
            n++;
            @(negedge clk);
        end
        start_i   = 1'b0;
        force_cmp = 1'b0;
        check(n == TERM, "R2/R7/R8 charge phase length", n, TERM);
        m = 0;
        while (ref_sel_o && m < MAXV + 10) begin
            start_i = poke_start && (m == 1);
            m++;
            @(negedge clk);
        end
        check(m == exp_m, "R3 reference phase length", m, exp_m);
        check(done_o == 1'b1, "R4 done after reference phase", int'(done_o), 1);
        start_i = poke_start;
        @(negedge clk) start_i = 1'b0;
        check(done_o == 1'b0, "R4 done cleared", int'(done_o), 0);
        last_res = e.res;
        last_ovr = e.ovr;
        if (poke_start) begin
            int seen;
            seen = 0;
            for (int i = 0; i < TERM + 5; i++) begin
                if (ref_sel_o || done_o) seen = 1;
                @(negedge clk);
            end
            check(seen == 0, "R7 start during completion ignored", seen, 0);
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(ref_sel_o == 1'b0 && done_o == 1'b0, "R1 reset outputs", int'(ref_sel_o), 0);
        check(result_o == '0 && ovr_o == 1'b0, "R1 reset result", int'(result_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(ref_sel_o == 1'b0 && done_o == 1'b0, "R1 idle after reset", int'(ref_sel_o), 0);

        run_conv(50, 1'b0, 1'b0);
        run_conv(0, 1'b0, 1'b0);
        run_conv(MAXV, 1'b0, 1'b0);          // R6 boundary: trips at last count
        run_conv(MAXV + 40, 1'b1, 1'b0);     // R6 saturation, R7 stray starts
        run_conv(100, 1'b0, 1'b1);           // R8 comparator noise, R6 flag clears
        run_conv(1, 1'b0, 1'b0);

        // R1: reset in the middle of the reference phase
        k_cur = 200;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        while (!ref_sel_o) @(negedge clk);
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(ref_sel_o == 1'b0 && done_o == 1'b0, "R1 abort outputs", int'(ref_sel_o), 0);
        check(result_o == '0 && ovr_o == 1'b0, "R1 abort result", int'(result_o), 0);
        rst = 1'b0;
        last_res = 0;
        last_ovr = 0;
        @(negedge clk);
        run_conv(7, 1'b0, 1'b0);

        repeat (5) @(negedge clk);
        check(sb_q.size() == 0, "R4 all completions seen", sb_q.size(), 0);
        check(dones == pushes, "R7 completion count", dones, pushes);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule